// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps the rows of an asynchronous DRAM refreshed without help from software. An interval timer earns one refresh credit per row period, which is the refresh period divided by the row count. A credit counter holds the credits that are still owed. While credits are owed and the scheduler owns no strobes, it raises a request to the access controller. When the controller grants the request, the scheduler drives the row strobe, the column strobe and the write enable itself. It runs one refresh cycle with the column strobe falling first, and each such cycle pays back one credit.

The request/grant pair behaves as a valid/ready handshake. `ref_req` stays high for as long as a credit is owed or `sr_req` is held, as long as the block is idle. A grant is taken only in a cycle where `ref_req` is high. In that cycle the block takes the strobes, and `busy` rises on the next edge. A grant in any other cycle has no effect, so the controller may hold `grant` high permanently. The controller must keep its own strobes inactive while `busy` is high.

Holding `sr_req` high when a grant arrives puts the DRAM into its low-power self-refresh state. The refresh cycle starts as usual, but the row strobe is then held low for at least the minimum self-refresh time and for as long as `sr_req` stays high. Owed credits are dropped and the timer is frozen. On exit, the row strobe stays high for the exit precharge time. Exactly one catch-up refresh cycle follows before `busy` drops. The row-count option (11 or 12 row-address bits) selects 2048 rows per 32 ms or 4096 rows per 64 ms.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted, `ras_n`, `cas_n` and `we_n` are 1 and `busy` is 0. After reset the credit counter holds 8 start-up credits, so `ref_req` and `urgent` read 1.
- R2: A grant is accepted only in a cycle with `ref_req` high, and `busy` is 1 on the next cycle. A grant while `ref_req` is 0 leaves the strobes at 1 and `busy` at 0. Once raised, `ref_req` stays 1 until a grant is accepted.
- R3: The timer adds one credit every INTERVAL clock cycles, where INTERVAL = floor(period_ns / rows / CLK_NS). With the defaults (4096 rows, 64 ms, 8 ns clock) INTERVAL is 1953, and the first credit lands on the 1953rd edge after reset is released.
- R4: Credits saturate at 8, and further timer credits are lost. `urgent` is 1 exactly when 8 credits are owed. Each refresh cycle pays back one credit.
- R5: In each refresh cycle `cas_n` is 0 for ceil(10 ns / CLK_NS) = 2 cycles before `ras_n` falls, and `we_n` is 1 when `ras_n` falls.
- R6: In a plain refresh cycle `ras_n` is 0 for ceil(max(50, 10) ns / CLK_NS) = 7 cycles, and `cas_n` stays 0 for all of that time.
- R7: `cas_n` rises ceil(5 ns / CLK_NS) = 1 cycle after `ras_n` rises. Both strobes then stay 1 for at least ceil(30 ns / CLK_NS) = 4 cycles before the next cycle starts.
- R8: `busy` is 1 in every cycle where either strobe is 0, and `ref_req` is never 1 while `busy` is 1.
- R9: If `sr_req` is 1 when a grant is accepted, `ras_n` stays 0 for at least ceil(100 us / CLK_NS) = 12500 cycles and until `sr_req` is 0. All owed credits are cleared, so `ref_req` is 0 once the sequence ends.
- R10: After self-refresh, `ras_n` stays high for at least ceil(95 ns / CLK_NS) = 12 cycles, counted from its rising edge. Exactly one plain refresh cycle then follows before `busy` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_req | input | 1 | Level request to enter and stay in self-refresh |
| grant | input | 1 | Access controller hands the strobes over (ready) |
| ref_req | output | 1 | Refresh wanted (valid) |
| urgent | output | 1 | Credit counter is full |
| busy | output | 1 | Scheduler owns the DRAM strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |

## Verification
A credit counter that drifts shows up as a wrong number of refresh cycles. The drift becomes visible at the first point where the scheduler goes idle with `ref_req` low. At that point the bench compares the refresh cycles it counted with the start-up credits plus the timer credits due from the elapsed cycles. A wrong dwell count in the strobe sequencer changes a pulse width or an edge offset. That error is caught on the very edge where the strobe moves. A stuck self-refresh mode shows up as a row-strobe pulse of the wrong class, or as a missing or extra catch-up cycle, and it is visible when `busy` drops.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_ROW,
    ST_TRAIL,
    ST_PRE,
    ST_SLEEP,
    ST_WAKE_TRAIL,
    ST_WAKE_PRE
  } ref_state_e;

  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
  parameter int unsigned INTERVAL = 1953
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = $clog2(INTERVAL + 1);
  localparam logic [CW-1:0] RELOAD = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= RELOAD;
    else if (!run || tick)   cnt <= RELOAD;
    else                     cnt <= cnt - 1'b1;
  end

  generate
    if (INTERVAL > 1) begin : g_gap
      a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/dram_ref_credits.sv
module dram_ref_credits #(
  parameter int unsigned MAX_CREDITS  = 8,
  parameter int unsigned INIT_CREDITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic consume,
  input  logic clear,
  output logic pending,
  output logic urgent
);
  localparam int unsigned CW = $clog2(MAX_CREDITS + 1);
  localparam logic [CW-1:0] FULL  = CW'(MAX_CREDITS);
  localparam logic [CW-1:0] START = CW'(INIT_CREDITS);

  logic [CW-1:0] credit;
  logic          inc, dec;

  assign inc     = tick;
  assign dec     = consume && (credit != '0);
  assign pending = (credit != '0);
  assign urgent  = (credit == FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           credit <= START;
    else if (clear)                       credit <= '0;
    else if (inc && !dec && !urgent)      credit <= credit + 1'b1;
    else if (dec && !inc)                 credit <= credit - 1'b1;
  end

  a_r4_cap: assert property (@(posedge clk) disable iff (!rst_n)
    credit <= FULL);
  a_r4_stay_full: assert property (@(posedge clk) disable iff (!rst_n)
    (urgent && tick && !consume && !clear) |=> urgent);
  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !pending);

endmodule

// File: rtl/dram_ref_seq.sv
module dram_ref_seq
  import dram_ref_pkg::*;
#(
  parameter int unsigned LEAD_CYC  = 2,
  parameter int unsigned ROW_CYC   = 7,
  parameter int unsigned TRAIL_CYC = 1,
  parameter int unsigned PRE_CYC   = 4,
  parameter int unsigned SLEEP_CYC = 12500,
  parameter int unsigned WAKE_CYC  = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic sr_req,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic busy,
  output logic cbr_done,
  output logic sleep_enter,
  output logic in_sleep
);
  localparam int unsigned CW = $clog2(SLEEP_CYC + 1);
  localparam logic [CW-1:0] LEAD_L  = CW'(LEAD_CYC - 1);
  localparam logic [CW-1:0] ROW_L   = CW'(ROW_CYC - 1);
  localparam logic [CW-1:0] TRAIL_L = CW'(TRAIL_CYC - 1);
  localparam logic [CW-1:0] PRE_L   = CW'(PRE_CYC - 1);
  localparam logic [CW-1:0] SLEEP_L = CW'(SLEEP_CYC - 1);
  localparam logic [CW-1:0] WAKE_L  = CW'(WAKE_CYC - 1);

  ref_state_e    state;
  logic [CW-1:0] cnt;
  logic          self_mode;
  logic          done;

  assign done = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      self_mode <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state     <= ST_LEAD;
          cnt       <= LEAD_L;
          self_mode <= sr_req;
        end
        ST_LEAD: if (!done) cnt <= cnt - 1'b1;
          else if (self_mode) begin state <= ST_SLEEP; cnt <= SLEEP_L; end
          else begin state <= ST_ROW; cnt <= ROW_L; end
        ST_ROW: if (!done) cnt <= cnt - 1'b1;
          else begin state <= ST_TRAIL; cnt <= TRAIL_L; end
        ST_TRAIL: if (!done) cnt <= cnt - 1'b1;
          else begin state <= ST_PRE; cnt <= PRE_L; end
        ST_PRE: if (!done) cnt <= cnt - 1'b1;
          else state <= ST_IDLE;
        ST_SLEEP: if (!done) cnt <= cnt - 1'b1;
          else if (!sr_req) begin state <= ST_WAKE_TRAIL; cnt <= TRAIL_L; end
        ST_WAKE_TRAIL: if (!done) cnt <= cnt - 1'b1;
          else begin state <= ST_WAKE_PRE; cnt <= WAKE_L; end
        ST_WAKE_PRE: if (!done) cnt <= cnt - 1'b1;
          else begin
            state     <= ST_LEAD;
            cnt       <= LEAD_L;
            self_mode <= 1'b0;
          end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ras_n = !(state == ST_ROW || state == ST_SLEEP);
    cas_n = !(state == ST_LEAD || state == ST_ROW || state == ST_TRAIL ||
              state == ST_SLEEP || state == ST_WAKE_TRAIL);
    we_n  = 1'b1;
    busy  = (state != ST_IDLE);
    cbr_done    = (state == ST_ROW) && done;
    sleep_enter = (state == ST_LEAD) && done && self_mode;
    in_sleep    = (state == ST_SLEEP || state == ST_WAKE_TRAIL || state == ST_WAKE_PRE);
  end

  a_r5_cas_before_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(!cas_n));
  a_r7_cas_after_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> !cas_n);
  a_r10_wake_to_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAKE_PRE && done) |=> (state == ST_LEAD && !self_mode));
  a_r9_hold_while_req: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP && sr_req) |=> !ras_n);

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_ref_pkg::*;
#(
  parameter int unsigned CLK_NS       = 8,
  parameter int unsigned ROW_BITS     = 12,
  parameter int unsigned MAX_CREDITS  = 8,
  parameter int unsigned INIT_CREDITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sr_req,
  input  logic grant,
  output logic ref_req,
  output logic urgent,
  output logic busy,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);
  localparam int unsigned PERIOD_NS = (ROW_BITS >= 12) ? 64_000_000 : 32_000_000;
  localparam int unsigned ROWS      = 1 << ROW_BITS;
  localparam int unsigned INTERVAL  = PERIOD_NS / ROWS / CLK_NS;
  localparam int unsigned LEAD_CYC  = ns_to_cyc(10, CLK_NS);
  localparam int unsigned ROW_CYC   = ns_to_cyc(50, CLK_NS) > ns_to_cyc(10, CLK_NS) ?
                                      ns_to_cyc(50, CLK_NS) : ns_to_cyc(10, CLK_NS);
  localparam int unsigned TRAIL_CYC = ns_to_cyc(5, CLK_NS);
  localparam int unsigned PRE_CYC   = ns_to_cyc(30, CLK_NS);
  localparam int unsigned SLEEP_CYC = ns_to_cyc(100_000, CLK_NS);
  localparam int unsigned WAKE_CYC  = ns_to_cyc(95, CLK_NS);

  logic tick, pending, start, cbr_done, sleep_enter, in_sleep;

  assign ref_req = (pending || sr_req) && !busy;
  assign start   = ref_req && grant;

  dram_ref_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(!in_sleep), .tick(tick)
  );

  dram_ref_credits #(.MAX_CREDITS(MAX_CREDITS), .INIT_CREDITS(INIT_CREDITS)) u_credits (
    .clk(clk), .rst_n(rst_n), .tick(tick), .consume(cbr_done),
    .clear(sleep_enter), .pending(pending), .urgent(urgent)
  );

  dram_ref_seq #(
    .LEAD_CYC(LEAD_CYC), .ROW_CYC(ROW_CYC), .TRAIL_CYC(TRAIL_CYC),
    .PRE_CYC(PRE_CYC), .SLEEP_CYC(SLEEP_CYC), .WAKE_CYC(WAKE_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .sr_req(sr_req),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .busy(busy),
    .cbr_done(cbr_done), .sleep_enter(sleep_enter), .in_sleep(in_sleep)
  );

  a_r2_req_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> !busy);
  a_r2_grant_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && grant) |=> busy);
  a_r8_strobes_owned: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !cas_n) |-> busy);

endmodule

// File: tb/dram_refresh_sched_bench.sv
module dram_refresh_sched_bench;
  localparam int INTERVAL = 64_000_000 / 4096 / 8;
  localparam int INIT     = 8;

  function automatic int cyc_of(input int ns);
    return (ns + 7) / 8;
  endfunction
  function automatic int credits_due(input int from_cyc, input int to_cyc);
    return to_cyc / INTERVAL - from_cyc / INTERVAL;
  endfunction

  localparam int LEAD_C  = (10 + 7) / 8;
  localparam int ROW_C   = (50 + 7) / 8;
  localparam int TRAIL_C = (5 + 7) / 8;
  localparam int PRE_C   = (30 + 7) / 8;
  localparam int SLEEP_C = (100_000 + 7) / 8;
  localparam int WAKE_C  = (95 + 7) / 8;

  logic clk = 0, rst_n = 0, sr_req = 0, grant = 0;
  logic ref_req, urgent, busy, ras_n, cas_n, we_n;

  dram_refresh_sched u_dram_refresh_sched (
    .clk(clk), .rst_n(rst_n), .sr_req(sr_req), .grant(grant),
    .ref_req(ref_req), .urgent(urgent), .busy(busy),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int cbr_cnt = 0, self_cnt = 0, post_cbr = 0;
  int phase = 0, len = 0, hi_len = 1000, last_trail = 0;
  bit after_self = 0, done = 0;
  logic p_req = 0, p_grant = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // strobe protocol monitor
  always @(negedge clk) if (rst_n) begin
    if (!ras_n || !cas_n) chk(busy, "R8 busy while strobe low", busy, 1);
    if (ref_req) chk(!busy, "R8 request while busy", busy, 0);
    if (p_req && !p_grant) chk(ref_req, "R2 request dropped before grant", ref_req, 1);
    case (phase)
      0: if (!ras_n) begin
           chk(0, "R5 row strobe fell without column lead", ras_n, 1);
         end else if (!cas_n) begin
           chk(hi_len + (after_self ? last_trail : 0) >= (after_self ? WAKE_C : PRE_C),
               after_self ? "R10 wake precharge" : "R7 precharge", hi_len, PRE_C);
           phase = 1; len = 1;
         end else hi_len++;
      1: if (cas_n) begin
           chk(0, "R5 column strobe rose early", cas_n, 0); phase = 0; hi_len = 1;
         end else if (!ras_n) begin
           chk(len == LEAD_C, "R5 column lead", len, LEAD_C);
           chk(we_n, "R5 write enable high", we_n, 1);
           phase = 2; len = 1;
         end else len++;
      2: if (ras_n) begin
           if (len >= SLEEP_C) begin
             self_cnt++; after_self = 1; post_cbr = 0;
           end else begin
             chk(len == ROW_C, "R6 row strobe width", len, ROW_C);
             cbr_cnt++;
             if (after_self) post_cbr++;
           end
           chk(!cas_n, "R7 column strobe trails", cas_n, 0);
           phase = 3; len = 1;
         end else begin
           if (cas_n) chk(0, "R6 column strobe rose inside row", cas_n, 0);
           len++;
         end
      default: if (cas_n) begin
           chk(len == TRAIL_C, "R7 column trail", len, TRAIL_C);
           last_trail = len; phase = 0; hi_len = 1;
         end else len++;
    endcase
    p_req = ref_req; p_grant = grant;
  end

  task automatic drain();
    grant = 1;
    @(negedge clk);
    while (busy || ref_req) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    int base, c0, exp_n, cg;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n, "R1 strobes high in reset", {ras_n, cas_n, we_n}, 7);
    chk(!busy, "R1 idle in reset", busy, 0);
    rst_n = 1;
    @(negedge clk);
    chk(ref_req, "R1 start-up request", ref_req, 1);
    chk(urgent, "R1 R4 start-up credits full", urgent, 1);

    // start-up credits drain
    drain();
    chk(cbr_cnt == INIT + credits_due(0, cyc), "R4 start-up refresh count", cbr_cnt,
        INIT + credits_due(0, cyc));
    chk(!urgent, "R4 urgent cleared", urgent, 0);

    // grant without request
    begin
      bit quiet = 1;
      for (int i = 0; i < 50; i++) begin
        @(negedge clk);
        if (!ras_n || !cas_n || busy) quiet = 0;
      end
      chk(quiet, "R2 grant ignored without request", quiet, 1);
    end

    // random grant pattern
    for (int i = 0; i < 5 * INTERVAL; i++) begin
      @(negedge clk);
      grant = ($urandom % 4) == 0;
    end
    drain();
    chk(cbr_cnt == INIT + credits_due(0, cyc), "R3 credits follow interval", cbr_cnt,
        INIT + credits_due(0, cyc));

    // short starvation
    grant = 0; base = cbr_cnt; c0 = cyc;
    repeat (3 * INTERVAL + 10) @(negedge clk);
    chk(ref_req, "R2 request held while starved", ref_req, 1);
    chk(!urgent, "R4 not full after three intervals", urgent, 0);
    drain();
    exp_n = credits_due(c0, cyc);
    chk(cbr_cnt - base == exp_n, "R3 R4 owed refreshes paid", cbr_cnt - base, exp_n);

    // saturation
    grant = 0; base = cbr_cnt;
    repeat (10 * INTERVAL) @(negedge clk);
    chk(urgent, "R4 urgent at cap", urgent, 1);
    cg = cyc;
    drain();
    exp_n = 8 + credits_due(cg, cyc);
    chk(cbr_cnt - base == exp_n, "R4 saturated backlog", cbr_cnt - base, exp_n);

    // self-refresh with owed credits
    grant = 0;
    repeat (2 * INTERVAL) @(negedge clk);
    sr_req = 1; grant = 1;
    @(negedge clk);
    while (ras_n) @(negedge clk);
    repeat (100) @(negedge clk);
    sr_req = 0;
    @(negedge clk);
    while (busy) @(negedge clk);
    chk(self_cnt == 1, "R9 long row strobe", self_cnt, 1);
    chk(post_cbr == 1, "R10 one catch-up refresh", post_cbr, 1);
    chk(!ref_req, "R9 credits cleared", ref_req, 0);
    chk(!urgent, "R9 urgent clear after wake", urgent, 0);

    done = 1;
    summary();
  end
endmodule